// File: doc/BRIEF.md
# Extended-Precision Rounding Unit

This block takes an unrounded floating-point result in the 80-bit internal format and rounds it. The input is a sign, a 15-bit biased exponent (bias 16383), a 64-bit mantissa whose leading integer bit is explicit, and three extra bits below the mantissa: guard, round and sticky. Two small control fields select how many mantissa bits are kept and which rounding direction is applied.

The rounding point moves inside the one 64-bit mantissa. Extended precision keeps all 64 bits, double keeps the top 53 and single keeps the top 24. The result stays in the 80-bit internal format, and the mantissa bits below the kept width are cleared. An inexact flag and an overflow flag come with the result. The result is registered, so it appears one clock after the operands. Denormal inputs, NaN operands and packing into memory formats are handled outside this block.

Top module: `rnd_ext_round`

## Requirements
- R1: `rnd_prec` selects the kept mantissa width: 2'b00 keeps 64 bits, 2'b01 keeps the top 24 bits and 2'b10 keeps the top 53 bits. The spare code 2'b11 behaves exactly like 2'b00. Mantissa bits below the kept width are always zero in the result.
- R2: `rnd_dir` selects the direction: 2'b00 is to nearest, 2'b01 is toward zero, 2'b10 is toward minus infinity and 2'b11 is toward plus infinity.
- R3: With direction to nearest, the kept part grows by one unit in the last place when the discarded part is more than half a unit. When it is exactly half a unit, the kept part grows only if its last bit is 1, so ties go to an even result.
- R4: With direction toward zero, the kept part is never incremented, and the exponent is unchanged unless the input exponent is 0x7FFF.
- R5: Toward minus infinity increments the magnitude only for a negative inexact value. Toward plus infinity increments it only for a positive inexact value.
- R6: If the increment carries out of the kept mantissa, the mantissa becomes 0x8000_0000_0000_0000 and the exponent goes up by one.
- R7: `flag_inexact` is 1 exactly when any discarded bit is non-zero: a mantissa bit below the kept width, guard, round or sticky. It is also 1 when `flag_overflow` is 1.
- R8: `flag_overflow` is 1 when the exponent after rounding is 0x7FFF or higher. The result is then infinity (exponent 0x7FFF, mantissa 0) when rounding to nearest, or when the direction points toward the value's own sign. Otherwise it is the largest finite value: exponent 0x7FFE with every kept mantissa bit set.
- R9: The sign of the result always equals the input sign.
- R10: All outputs are registered and show the result for the operands presented one clock earlier. A synchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sign | input | 1 | Sign of the unrounded value |
| in_exp | input | 15 | Biased exponent, excess 16383 |
| in_mant | input | 64 | Mantissa with explicit integer bit |
| in_guard | input | 1 | First bit below the mantissa |
| in_round | input | 1 | Second bit below the mantissa |
| in_sticky | input | 1 | OR of all lower bits |
| rnd_prec | input | 2 | Kept-width select |
| rnd_dir | input | 2 | Rounding direction select |
| res_sign | output | 1 | Result sign |
| res_exp | output | 15 | Result exponent |
| res_mant | output | 64 | Result mantissa, kept bits only |
| flag_inexact | output | 1 | Discarded bits were non-zero, or overflow |
| flag_overflow | output | 1 | Exponent reached 0x7FFF after rounding |

## Verification
The main sweep covers every precision code, every direction and both signs. At each kept width it walks a five-bit window that spans the two lowest kept bits, the first discarded bit and the two bits below it, and it sets or clears one stray bit further down. The window tells below-half, exact-tie and above-half apart, and it tells an even kept LSB from an odd one. The stray bit tells an exact tie from a value just above half.

Each window pattern is run twice: once over a mostly-zero mantissa and once over a mantissa whose kept bits are all ones. The all-ones case forces the renormalising carry. Each pattern is also run with a mid-range exponent and with exponent 0x7FFE, which separates an ordinary carry from overflow and shows the infinity versus largest-finite choice for each direction and sign.

// File: rtl/rnd_pkg.sv
// Package: shared encodings for the extended-precision rounding unit.
// Assumes the 2-bit precision and direction fields listed in the brief.
package rnd_pkg;

    typedef enum logic [1:0] {
        PREC_EXT   = 2'b00,
        PREC_SGL   = 2'b01,
        PREC_DBL   = 2'b10,
        PREC_SPARE = 2'b11
    } prec_e;

    typedef enum logic [1:0] {
        DIR_NEAR  = 2'b00,
        DIR_ZERO  = 2'b01,
        DIR_MINUS = 2'b10,
        DIR_PLUS  = 2'b11
    } dir_e;

    // Number of kept-width variants built in hardware (ext, single, double).
    localparam int NUM_WIDTHS = 3;

    // Map a precision code to its variant index; the spare code maps to extended.
    function automatic int unsigned width_index(input logic [1:0] prec);
        case (prec)
            PREC_SGL: width_index = 1;
            PREC_DBL: width_index = 2;
            default:  width_index = 0;
        endcase
    endfunction

endpackage

// File: rtl/rnd_point.sv
// Module: rnd_point
// Finds the rounding point inside the mantissa for the selected precision.
// It produces the kept-bit mask, the one-hot weight of the kept LSB, the LSB
// value, the first discarded bit and the OR of every lower discarded bit.
// Assumes KEEP widths of at least 2 bits and at most MANT_W.
module rnd_point
    import rnd_pkg::*;
#(
    parameter int MANT_W   = 64,
    parameter int SGL_KEEP = 24,
    parameter int DBL_KEEP = 53
) (
    input  logic [1:0]        prec,
    input  logic [MANT_W-1:0] mant,
    input  logic              guard_b,
    input  logic              round_b,
    input  logic              sticky_b,
    output logic [MANT_W-1:0] keep_mask,
    output logic [MANT_W-1:0] lsb_step,
    output logic              lsb_bit,
    output logic              half_bit,
    output logic              below_bit
);

    logic [NUM_WIDTHS-1:0][MANT_W-1:0] mask_v;
    logic [NUM_WIDTHS-1:0][MANT_W-1:0] step_v;
    logic [NUM_WIDTHS-1:0]             half_v;
    logic [NUM_WIDTHS-1:0]             below_v;
    logic                              tail_any;

    // Purpose: guard, round and sticky always count as discarded bits.
    assign tail_any = guard_b | round_b | sticky_b;

    for (genvar gi = 0; gi < NUM_WIDTHS; gi++) begin : g_width
        localparam int KEEP = (gi == 1) ? SGL_KEEP : (gi == 2) ? DBL_KEEP : MANT_W;
        localparam int DROP = MANT_W - KEEP;

        // Purpose: constant masks for this kept width.
        assign mask_v[gi] = {MANT_W{1'b1}} << DROP;
        assign step_v[gi] = {{(MANT_W-1){1'b0}}, 1'b1} << DROP;

        if (DROP == 0) begin : g_full
            // Purpose: all mantissa bits kept; the tail bits decide.
            assign half_v[gi]  = guard_b;
            assign below_v[gi] = round_b | sticky_b;
        end else if (DROP == 1) begin : g_one
            // Purpose: a single mantissa bit is dropped.
            assign half_v[gi]  = mant[0];
            assign below_v[gi] = tail_any;
        end else begin : g_many
            // Purpose: several mantissa bits are dropped.
            assign half_v[gi]  = mant[DROP-1];
            assign below_v[gi] = (|mant[DROP-2:0]) | tail_any;
        end
    end

    // Purpose: pick the variant named by the precision field.
    always_comb begin
        keep_mask = mask_v[width_index(prec)];
        lsb_step  = step_v[width_index(prec)];
        half_bit  = half_v[width_index(prec)];
        below_bit = below_v[width_index(prec)];
        lsb_bit   = |(mant & lsb_step);
    end

endmodule

// File: rtl/rnd_decide.sv
// Module: rnd_decide
// Decides whether the kept part is incremented by one unit in the last place,
// and whether the value is inexact before any overflow is considered.
// Assumes the half/below split produced by rnd_point.
module rnd_decide
    import rnd_pkg::*;
(
    input  logic [1:0] dir,
    input  logic       sign,
    input  logic       lsb_bit,
    input  logic       half_bit,
    input  logic       below_bit,
    output logic       bump,
    output logic       lost
);

    // Purpose: choose the increment for each direction.
    always_comb begin
        lost = half_bit | below_bit;
        case (dir)
            DIR_NEAR:  bump = half_bit & (below_bit | lsb_bit);
            DIR_ZERO:  bump = 1'b0;
            DIR_MINUS: bump = sign & lost;
            default:   bump = ~sign & lost;
        endcase
    end

endmodule

// File: rtl/rnd_apply.sv
// Module: rnd_apply
// Adds the increment to the kept mantissa, renormalises on carry-out, and
// replaces the result with infinity or the largest finite value on overflow.
// Assumes a normalised input; exponent 0x7FFF on input counts as overflow.
module rnd_apply
    import rnd_pkg::*;
#(
    parameter int MANT_W = 64,
    parameter int EXP_W  = 15
) (
    input  logic [MANT_W-1:0] mant,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [MANT_W-1:0] keep_mask,
    input  logic [MANT_W-1:0] lsb_step,
    input  logic              bump,
    input  logic              lost,
    input  logic [1:0]        dir,
    input  logic              sign,
    output logic [EXP_W-1:0]  exp_out,
    output logic [MANT_W-1:0] mant_out,
    output logic              inexact,
    output logic              overflow
);

    localparam logic [EXP_W:0]    EXP_TOP  = {1'b0, {EXP_W{1'b1}}};
    localparam logic [EXP_W-1:0]  EXP_FIN  = {{(EXP_W-1){1'b1}}, 1'b0};
    localparam logic [MANT_W-1:0] MANT_ONE = {1'b1, {(MANT_W-1){1'b0}}};

    logic [MANT_W:0]   sum;
    logic              carry;
    logic [MANT_W-1:0] mant_rnd;
    logic [EXP_W:0]    exp_sum;
    logic              to_inf;

    // Purpose: truncated mantissa plus the optional unit in the last place.
    always_comb begin
        sum      = {1'b0, mant & keep_mask} + ({1'b0, lsb_step} & {(MANT_W+1){bump}});
        carry    = sum[MANT_W];
        mant_rnd = carry ? MANT_ONE : sum[MANT_W-1:0];
        exp_sum  = {1'b0, exp_in} + {{EXP_W{1'b0}}, carry};
    end

    // Purpose: overflow detection and the saturated result choice.
    always_comb begin
        overflow = (exp_sum >= EXP_TOP);
        to_inf   = (dir == DIR_NEAR) || (dir == DIR_PLUS && !sign) ||
                   (dir == DIR_MINUS && sign);
        inexact  = lost | overflow;
        if (!overflow) begin
            exp_out  = exp_sum[EXP_W-1:0];
            mant_out = mant_rnd;
        end else if (to_inf) begin
            exp_out  = EXP_TOP[EXP_W-1:0];
            mant_out = '0;
        end else begin
            exp_out  = EXP_FIN;
            mant_out = keep_mask;
        end
    end

endmodule

// File: rtl/rnd_ext_round.sv
// Module: rnd_ext_round (top)
// Rounds an 80-bit internal-format value to extended, double or single width
// under one of four directions, with one clock of latency.
// Assumes normalised operands; denormals and NaNs are handled elsewhere.
module rnd_ext_round
    import rnd_pkg::*;
#(
    parameter int MANT_W   = 64,
    parameter int EXP_W    = 15,
    parameter int SGL_KEEP = 24,
    parameter int DBL_KEEP = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    input  logic              in_guard,
    input  logic              in_round,
    input  logic              in_sticky,
    input  logic [1:0]        rnd_prec,
    input  logic [1:0]        rnd_dir,
    output logic              res_sign,
    output logic [EXP_W-1:0]  res_exp,
    output logic [MANT_W-1:0] res_mant,
    output logic              flag_inexact,
    output logic              flag_overflow
);

    localparam int          SGL_DROP = MANT_W - SGL_KEEP;
    localparam logic [EXP_W-1:0] EXP_ALL = {EXP_W{1'b1}};

    logic [MANT_W-1:0] keep_mask, lsb_step, mant_nx;
    logic              lsb_bit, half_bit, below_bit, bump, lost;
    logic [EXP_W-1:0]  exp_nx;
    logic              inexact_nx, overflow_nx;

    rnd_point #(.MANT_W(MANT_W), .SGL_KEEP(SGL_KEEP), .DBL_KEEP(DBL_KEEP)) u_point (
        .prec(rnd_prec), .mant(in_mant), .guard_b(in_guard), .round_b(in_round),
        .sticky_b(in_sticky), .keep_mask(keep_mask), .lsb_step(lsb_step),
        .lsb_bit(lsb_bit), .half_bit(half_bit), .below_bit(below_bit)
    );

    rnd_decide u_decide (
        .dir(rnd_dir), .sign(in_sign), .lsb_bit(lsb_bit), .half_bit(half_bit),
        .below_bit(below_bit), .bump(bump), .lost(lost)
    );

    rnd_apply #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_apply (
        .mant(in_mant), .exp_in(in_exp), .keep_mask(keep_mask), .lsb_step(lsb_step),
        .bump(bump), .lost(lost), .dir(rnd_dir), .sign(in_sign),
        .exp_out(exp_nx), .mant_out(mant_nx), .inexact(inexact_nx), .overflow(overflow_nx)
    );

    // Purpose: output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_sign      <= 1'b0;
            res_exp       <= '0;
            res_mant      <= '0;
            flag_inexact  <= 1'b0;
            flag_overflow <= 1'b0;
        end else begin
            res_sign      <= in_sign;
            res_exp       <= exp_nx;
            res_mant      <= mant_nx;
            flag_inexact  <= inexact_nx;
            flag_overflow <= overflow_nx;
        end
    end

    // Purpose: marks cycles whose outputs come from operands sampled out of reset.
    logic r_live;
    always_ff @(posedge clk) begin
        if (!rst_n) r_live <= 1'b0;
        else        r_live <= 1'b1;
    end

    a_r9_sign_follows: assert property (@(posedge clk) disable iff (!rst_n)
        r_live |-> res_sign == $past(in_sign));

    a_r4_zero_keeps_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (r_live && $past(rnd_dir) == DIR_ZERO && $past(in_exp) != EXP_ALL)
        |-> res_exp == $past(in_exp));

    a_r1_single_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (r_live && $past(rnd_prec) == PREC_SGL) |-> res_mant[SGL_DROP-1:0] == '0);

    a_r8_overflow_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow |-> flag_inexact);

    a_r7_exact_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (r_live && !$past(in_guard) && !$past(in_round) && !$past(in_sticky) &&
         ($past(rnd_prec) == PREC_EXT || $past(rnd_prec) == PREC_SPARE) &&
         $past(in_exp) != EXP_ALL)
        |-> (!flag_inexact && res_mant == $past(in_mant)));

endmodule

// File: tb/test_rnd_ext_round.sv
module test_rnd_ext_round;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_sign = 1'b0;
    logic [14:0] in_exp = '0;
    logic [63:0] in_mant = '0;
    logic        in_guard = 1'b0, in_round = 1'b0, in_sticky = 1'b0;
    logic [1:0]  rnd_prec = 2'b00, rnd_dir = 2'b00;
    logic        res_sign;
    logic [14:0] res_exp;
    logic [63:0] res_mant;
    logic        flag_inexact, flag_overflow;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    rnd_ext_round i_rnd_ext_round (
        .clk(clk), .rst_n(rst_n), .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
        .in_guard(in_guard), .in_round(in_round), .in_sticky(in_sticky),
        .rnd_prec(rnd_prec), .rnd_dir(rnd_dir), .res_sign(res_sign), .res_exp(res_exp),
        .res_mant(res_mant), .flag_inexact(flag_inexact), .flag_overflow(flag_overflow)
    );

    // Arithmetic model: {sign, exp, mant, inexact, overflow}.
    function automatic logic [81:0] model(input logic s, input logic [14:0] e,
                                          input logic [66:0] full,
                                          input logic [1:0] prec, input logic [1:0] dir);
        int          keep, d;
        logic [67:0] q, rem, half, qn;
        logic        inx, up, carry, ovf;
        logic [16:0] ex;
        logic [63:0] m;
        keep = (prec == 2'b01) ? 24 : (prec == 2'b10) ? 53 : 64;
        d    = 67 - keep;
        q    = {1'b0, full} >> d;
        rem  = {1'b0, full} - (q << d);
        half = 68'd1 << (d - 1);
        inx  = (rem != 0);
        case (dir)
            2'b00:   up = (rem > half) || (rem == half && q[0]);
            2'b01:   up = 1'b0;
            2'b10:   up = s && inx;
            default: up = !s && inx;
        endcase
        qn    = q + {67'd0, up};
        carry = (qn == (68'd1 << keep));
        m     = carry ? 64'h8000_0000_0000_0000 : 64'(qn << (64 - keep));
        ex    = {2'b0, e} + {16'd0, carry};
        ovf   = (ex >= 17'h7FFF);
        if (ovf) begin
            inx = 1'b1;
            if (dir == 2'b00 || (dir == 2'b11 && !s) || (dir == 2'b10 && s)) begin
                ex = 17'h7FFF; m = '0;
            end else begin
                ex = 17'h7FFE; m = ~64'd0 << (64 - keep);
            end
        end
        return {s, ex[14:0], m, inx, ovf};
    endfunction

    // Drive one operand set, wait one clock, compare against the model.
    task automatic apply(input logic s, input logic [14:0] e, input logic [66:0] full,
                         input logic [1:0] prec, input logic [1:0] dir, input string tag);
        logic [81:0] exp_v, got;
        @(negedge clk);
        in_sign = s; in_exp = e; in_mant = full[66:3];
        in_guard = full[2]; in_round = full[1]; in_sticky = full[0];
        rnd_prec = prec; rnd_dir = dir;
        @(posedge clk);
        @(negedge clk);
        exp_v = model(s, e, full, prec, dir);
        got   = {res_sign, res_exp, res_mant, flag_inexact, flag_overflow};
        checks++;
        if (got !== exp_v) begin
            errors++;
            $display("FAIL %s prec=%b dir=%b: actual=%h expected=%h", tag, prec, dir, got, exp_v);
        end
    endtask

    function automatic string sweep_tag(input logic [1:0] dir, input logic [14:0] e);
        if (e == 15'h7FFE) return "R8";
        case (dir)
            2'b00:   return "R3";
            2'b01:   return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset clears every output.
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({res_sign, res_exp, res_mant, flag_inexact, flag_overflow} !== '0) begin
            errors++;
            $display("FAIL R10 reset: actual=%h expected=0",
                     {res_sign, res_exp, res_mant, flag_inexact, flag_overflow});
        end
        rst_n = 1'b1;

        // R3 ties to even, single width (round bit at mantissa bit 39).
        apply(1'b0, 15'h3FFF, {64'h8000_0080_0000_0000, 3'b000}, 2'b01, 2'b00, "R3 tie-even-stay");
        apply(1'b0, 15'h3FFF, {64'h8000_0180_0000_0000, 3'b000}, 2'b01, 2'b00, "R3 tie-odd-up");
        // R6 carry renormalises at double width.
        apply(1'b1, 15'h4000, {64'hFFFF_FFFF_FFFF_F800, 3'b100}, 2'b10, 2'b10, "R6 carry");
        // R1 spare code acts as extended; R7 only sticky set.
        apply(1'b0, 15'h3FFF, {64'h8000_0000_0000_0001, 3'b001}, 2'b11, 2'b11, "R1 spare");
        apply(1'b0, 15'h3FFF, {64'h8000_0000_0000_0000, 3'b001}, 2'b00, 2'b01, "R7 sticky-only");
        // R2/R8 overflow per direction, R9 sign passes.
        for (int dd = 0; dd < 4; dd++) begin
            apply(1'b1, 15'h7FFE, {64'hFFFF_FFFF_FFFF_FFFF, 3'b111}, 2'b00, 2'(dd), "R8 ovf neg");
            apply(1'b0, 15'h7FFE, {64'hFFFF_FFFF_FFFF_FFFF, 3'b111}, 2'b00, 2'(dd), "R2 ovf pos");
        end
        apply(1'b1, 15'h0123, {64'hC000_0000_0000_0000, 3'b000}, 2'b01, 2'b11, "R9 sign");

        // Sweep: window around the rounding point for every mode.
        for (int p = 0; p < 4; p++)
            for (int dr = 0; dr < 4; dr++)
                for (int sg = 0; sg < 2; sg++)
                    for (int eb = 0; eb < 2; eb++)
                        for (int hb = 0; hb < 2; hb++)
                            for (int t = 0; t < 32; t++)
                                for (int x = 0; x < 2; x++) begin
                                    int          keep, d;
                                    logic [66:0] full;
                                    logic [14:0] e;
                                    keep = (p == 1) ? 24 : (p == 2) ? 53 : 64;
                                    d    = 67 - keep;
                                    full = (hb != 0) ? (~67'd0 << (d + 2)) : (67'd1 << 66);
                                    full = full | (67'(t) << (d - 3)) | 67'(x);
                                    e    = (eb != 0) ? 15'h7FFE : 15'h3FFF;
                                    apply(sg[0], e, full, 2'(p), 2'(dr), sweep_tag(2'(dr), e));
                                end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule